// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one compare channel attached to an up-counting timer. It watches the timer count on every clock, compares it against two programmable 16-bit values and drives one output pin. Six pin behaviours can be selected, plus an off state. Three modes act on a single match: drive the pin low, drive it high, or toggle it. Two modes generate pulses from two matches, one for the rising edge and one for the falling edge, as a single pulse or a repeating train. One mode is a simple PWM whose duty value is double-buffered, so a new duty value takes effect only at a period boundary and no pulse is ever cut short.

Software writes the two compare values through a small register port and selects the behaviour with a mode write. The timer, which is outside this block, supplies its count and a one-cycle strobe when it reaches its period. Each pin change caused by a compare or period event also produces a one-cycle interrupt pulse. Every event presented in a cycle takes effect on the pin at the clock edge that ends that cycle.

Top module: `ocmp_channel`

## Requirements
- R1: While and after a synchronous active-high reset, `pin_out` and `match_irq` are 0 and the channel is in the off state.
- R2: A write on `mode_wr` selects the behaviour from `mode_wdata`: 0 off, 1 low-on-match, 2 high-on-match, 3 toggle, 4 single pulse, 5 continuous pulses, 6 PWM. Code 7 acts as off. The mode write sets the pin at the next edge, high for code 1 and low for every other code, and never raises `match_irq`.
- R3: In low-on-match mode the pin goes low at the edge after the timer count equals the primary value, then stays low.
- R4: In high-on-match mode the pin goes high at the edge after the count equals the primary value, then stays high.
- R5: In toggle mode each new match inverts the pin. A count held equal to the primary value for several cycles counts as one match.
- R6: In single-pulse mode the pin rises on a primary match and falls on a later secondary match. After that it stays low and ignores matches until the mode is written again.
- R7: In continuous-pulse mode the rise/fall sequence of R6 repeats for as long as the mode stays selected.
- R8: In PWM mode a period strobe copies the secondary (buffer) value into the primary (active) value, and the pin goes high if that buffer is nonzero. The pin goes low when the count equals the active value. Register-port writes to the primary value (`reg_sel`=0) are ignored in this mode.
- R9: In PWM mode a duty of zero keeps the pin low through the period, and a duty larger than the period keeps it high.
- R10: `match_irq` is a one-cycle pulse, raised at the same edge where a compare or period event changes the pin, and only then.
- R11: Selecting off drives the pin low at the next edge and discards a pulse in progress. A later pulse mode starts waiting for a primary match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_cnt | input | 16 | Current count of the selected timer |
| tmr_prd_hit | input | 1 | One-cycle strobe when the timer reaches its period |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 primary, 1 secondary |
| reg_wdata | input | 16 | Register write data |
| mode_wr | input | 1 | Mode write enable |
| mode_wdata | input | 3 | Mode code (see R2) |
| pin_out | output | 1 | Compare output pin |
| match_irq | output | 1 | One-cycle pulse on every event-driven pin change |

## Verification
A corrupted pulse phase shows as a pin edge that is missing or extra on the first match after the fault. For example, a single-pulse channel that rises a second time shows it within one cycle of the next primary match. If the edge detector wrongly re-fires on a held count, the toggle output flips in the very next cycle. A PWM active value that reloads at the wrong moment appears as a falling edge at the old duty count in the period right after a buffer write. Since the interrupt must follow each event-driven pin change at the same edge, a mismatch between the pin and `match_irq` shows up in the same cycle.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 3'd0,
        MODE_LOW    = 3'd1,
        MODE_HIGH   = 3'd2,
        MODE_TOGGLE = 3'd3,
        MODE_ONE    = 3'd4,
        MODE_CONT   = 3'd5,
        MODE_PWM    = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_WAIT_RISE = 2'd1,
        PH_WAIT_FALL = 2'd2,
        PH_DONE      = 2'd3
    } phase_e;

    typedef struct packed {
        logic prim_hit;
        logic sec_hit;
        logic prd_hit;
    } events_t;

    function automatic mode_e decode_mode(input logic [MODE_W-1:0] code);
        if (code == 3'd7)
            return MODE_OFF;
        return mode_e'(code);
    endfunction

    function automatic logic is_pulse_mode(input mode_e m);
        return (m == MODE_ONE) || (m == MODE_CONT);
    endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] ref_val,
    output logic             hit
);
    logic eq_now;
    logic eq_prev;

    assign eq_now = (cnt == ref_val);
    assign hit    = eq_now && !eq_prev;

    always_ff @(posedge clk) begin
        if (rst)
            eq_prev <= 1'b0;
        else
            eq_prev <= eq_now;
    end
endmodule

// File: rtl/ocmp_regs.sv
module ocmp_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             pwm_active,
    input  logic             prd_hit,
    output logic [CNT_W-1:0] prim_q,
    output logic [CNT_W-1:0] sec_q
);
    logic prim_wr_ok;
    logic reload;

    assign prim_wr_ok = reg_wr && !reg_sel && !pwm_active;
    assign reload     = pwm_active && prd_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
            sec_q  <= '0;
        end else begin
            if (reload)
                prim_q <= sec_q;
            else if (prim_wr_ok)
                prim_q <= reg_wdata;
            if (reg_wr && reg_sel)
                sec_q <= reg_wdata;
        end
    end

    // R8: the active value follows the buffer at a period strobe
    a_r8_reload_from_buffer: assert property (@(posedge clk) disable iff (rst)
        (pwm_active && prd_hit) |=> (prim_q == $past(sec_q)));

    // R8: outside a period strobe the active value cannot move in PWM mode
    a_r8_active_locked: assert property (@(posedge clk) disable iff (rst)
        (pwm_active && !prd_hit) |=> $stable(prim_q));
endmodule

// File: rtl/ocmp_ctrl.sv
module ocmp_ctrl
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  events_t           ev,
    input  logic [CNT_W-1:0]  duty_buf,
    output logic              pwm_active,
    output logic              pin_q,
    output logic              irq_q
);
    mode_e  mode_q;
    phase_e phase_q;
    mode_e  new_mode;

    assign new_mode   = decode_mode(mode_wdata);
    assign pwm_active = (mode_q == MODE_PWM);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_OFF;
            phase_q <= PH_IDLE;
            pin_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (mode_wr) begin
                mode_q  <= new_mode;
                pin_q   <= (new_mode == MODE_LOW);
                phase_q <= is_pulse_mode(new_mode) ? PH_WAIT_RISE : PH_IDLE;
            end else begin
                unique case (mode_q)
                    MODE_LOW: begin
                        if (ev.prim_hit && pin_q) begin
                            pin_q <= 1'b0;
                            irq_q <= 1'b1;
                        end
                    end
                    MODE_HIGH: begin
                        if (ev.prim_hit && !pin_q) begin
                            pin_q <= 1'b1;
                            irq_q <= 1'b1;
                        end
                    end
                    MODE_TOGGLE: begin
                        if (ev.prim_hit) begin
                            pin_q <= !pin_q;
                            irq_q <= 1'b1;
                        end
                    end
                    MODE_ONE, MODE_CONT: begin
                        if (phase_q == PH_WAIT_RISE && ev.prim_hit) begin
                            pin_q   <= 1'b1;
                            irq_q   <= 1'b1;
                            phase_q <= PH_WAIT_FALL;
                        end else if (phase_q == PH_WAIT_FALL && ev.sec_hit) begin
                            pin_q   <= 1'b0;
                            irq_q   <= 1'b1;
                            phase_q <= (mode_q == MODE_ONE) ? PH_DONE : PH_WAIT_RISE;
                        end
                    end
                    MODE_PWM: begin
                        if (ev.prd_hit) begin
                            pin_q <= (duty_buf != '0);
                            irq_q <= ((duty_buf != '0) != pin_q);
                        end else if (ev.prim_hit && pin_q) begin
                            pin_q <= 1'b0;
                            irq_q <= 1'b1;
                        end
                    end
                    default: begin
                        pin_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R11: selecting off forces the pin low at the next edge
    a_r11_off_forces_low: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && decode_mode(mode_wdata) == MODE_OFF) |=> !pin_q);

    // R10: an event-driven pin change carries an interrupt pulse
    a_r10_change_has_irq: assert property (@(posedge clk) disable iff (rst)
        ((pin_q != $past(pin_q)) && !$past(mode_wr)) |-> irq_q);

    // R10: an interrupt pulse only accompanies a pin change
    a_r10_irq_needs_change: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (pin_q != $past(pin_q)));

    // R4: once high in high-on-match mode the pin holds
    a_r4_high_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HIGH && pin_q && !mode_wr) |=> pin_q);

    // R6: a finished single pulse keeps the pin low
    a_r6_done_is_low: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |-> !pin_q);
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  tmr_cnt,
    input  logic              tmr_prd_hit,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic              pin_out,
    output logic              match_irq
);
    localparam int NCMP = 2;

    logic [CNT_W-1:0] prim_val;
    logic [CNT_W-1:0] sec_val;
    logic [CNT_W-1:0] cmp_ref [NCMP];
    logic [NCMP-1:0]  cmp_hit;
    logic             pwm_active;
    events_t          ev;

    assign cmp_ref[0] = prim_val;
    assign cmp_ref[1] = sec_val;

    ocmp_regs #(.CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .pwm_active (pwm_active),
        .prd_hit    (tmr_prd_hit),
        .prim_q     (prim_val),
        .sec_q      (sec_val)
    );

    for (genvar gi = 0; gi < NCMP; gi++) begin : g_cmp
        ocmp_match #(.CNT_W(CNT_W)) match_i (
            .clk     (clk),
            .rst     (rst),
            .cnt     (tmr_cnt),
            .ref_val (cmp_ref[gi]),
            .hit     (cmp_hit[gi])
        );
    end

    assign ev.prim_hit = cmp_hit[0];
    assign ev.sec_hit  = cmp_hit[1];
    assign ev.prd_hit  = tmr_prd_hit;

    ocmp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .ev         (ev),
        .duty_buf   (sec_val),
        .pwm_active (pwm_active),
        .pin_q      (pin_out),
        .irq_q      (match_irq)
    );

    // R1: reset leaves the pin and interrupt quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!pin_out && !match_irq));
endmodule

// File: tb/ocmp_channel_tb_top.sv
module ocmp_channel_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr_cnt = 16'd500;
    logic        tmr_prd_hit = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_wdata = '0;
    logic        pin_out;
    logic        match_irq;

    typedef struct {
        logic  pin;
        logic  irq;
        string tag;
    } exp_t;

    exp_t exp_q [$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocmp_channel dut_i (
        .clk         (clk),
        .rst         (rst),
        .tmr_cnt     (tmr_cnt),
        .tmr_prd_hit (tmr_prd_hit),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .pin_out     (pin_out),
        .match_irq   (match_irq)
    );

    // Monitor: compares the design's outputs against the scoreboard
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (pin_out !== e.pin || match_irq !== e.irq) begin
                n_fail++;
                $display("FAIL %s: pin=%0b irq=%0b expected pin=%0b irq=%0b",
                         e.tag, pin_out, match_irq, e.pin, e.irq);
            end
        end
    end

    // Driver: one cycle of stimulus plus its expected result
    task automatic step(input logic [15:0] c, input logic p,
                        input logic wr, input logic sel, input logic [15:0] d,
                        input logic mw, input logic [2:0] md,
                        input logic ep, input logic ei, input string tag);
        exp_t e;
        @(negedge clk);
        tmr_cnt     = c;
        tmr_prd_hit = p;
        reg_wr      = wr;
        reg_sel     = sel;
        reg_wdata   = d;
        mode_wr     = mw;
        mode_wdata  = md;
        e.pin = ep;
        e.irq = ei;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic tick(input logic [15:0] c, input logic p,
                        input logic ep, input logic ei, input string tag);
        step(c, p, 1'b0, 1'b0, '0, 1'b0, '0, ep, ei, tag);
    endtask

    task automatic wreg(input logic sel, input logic [15:0] d,
                        input logic [15:0] c, input logic ep, input string tag);
        step(c, 1'b0, 1'b1, sel, d, 1'b0, '0, ep, 1'b0, tag);
    endtask

    task automatic wmode(input logic [2:0] m, input logic ep, input string tag);
        step(16'd500, 1'b0, 1'b0, 1'b0, '0, 1'b1, m, ep, 1'b0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG_LIMIT) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WDOG_LIMIT);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick(500, 0, 0, 0, "R1 reset state");
        wreg(0, 10, 500, 0, "R1 primary write");
        wreg(1, 20, 500, 0, "R1 secondary write");

        // R2 / R3 low-on-match
        wmode(3'd1, 1, "R2 low mode starts high");
        tick(9, 0, 1, 0, "R3 before match");
        tick(10, 0, 0, 1, "R3 match drives low");
        tick(11, 0, 0, 0, "R3 stays low");
        tick(10, 0, 0, 0, "R3 no second event");

        // R4 high-on-match
        wmode(3'd2, 0, "R2 high mode starts low");
        tick(10, 0, 1, 1, "R4 match drives high");
        tick(10, 0, 1, 0, "R4 held count");
        tick(11, 0, 1, 0, "R4 stays high");

        // R5 toggle
        wmode(3'd3, 0, "R2 toggle starts low");
        tick(10, 0, 1, 1, "R5 first toggle");
        tick(10, 0, 1, 0, "R5 held count is one match");
        tick(11, 0, 1, 0, "R5 no match");
        tick(10, 0, 0, 1, "R5 second toggle");

        // R6 single pulse
        wmode(3'd4, 0, "R2 single pulse starts low");
        tick(10, 0, 1, 1, "R6 rising edge");
        tick(15, 0, 1, 0, "R6 pulse held");
        tick(20, 0, 0, 1, "R6 falling edge");
        tick(10, 0, 0, 0, "R6 no second pulse");
        tick(20, 0, 0, 0, "R6 stays idle");

        // R7 continuous pulses
        wmode(3'd5, 0, "R2 continuous starts low");
        tick(10, 0, 1, 1, "R7 rise 1");
        tick(20, 0, 0, 1, "R7 fall 1");
        tick(10, 0, 1, 1, "R7 rise 2");
        tick(20, 0, 0, 1, "R7 fall 2");
        tick(10, 0, 1, 1, "R7 rise 3");

        // R11 disable mid-pulse
        wmode(3'd0, 0, "R11 off forces low");
        tick(20, 0, 0, 0, "R11 off ignores match");
        wmode(3'd4, 0, "R11 rearm single pulse");
        tick(20, 0, 0, 0, "R11 pending fall discarded");
        tick(10, 0, 1, 1, "R11 fresh rise");
        wmode(3'd7, 0, "R2 code 7 acts as off");
        tick(10, 0, 0, 0, "R2 code 7 ignores match");

        // R8 PWM
        wmode(3'd6, 0, "R2 pwm starts low");
        wreg(1, 3, 500, 0, "R8 duty buffer write");
        tick(5, 1, 1, 1, "R8 period sets pin");
        tick(0, 0, 1, 0, "R8 count 0");
        tick(1, 0, 1, 0, "R8 count 1");
        tick(2, 0, 1, 0, "R8 count 2");
        tick(3, 0, 0, 1, "R8 duty match");
        tick(4, 0, 0, 0, "R8 stays low");
        wreg(0, 1, 4, 0, "R8 primary write ignored");
        wreg(1, 2, 4, 0, "R8 new duty buffered");
        tick(5, 1, 1, 1, "R8 period reload");
        tick(0, 0, 1, 0, "R8 count 0 again");
        tick(1, 0, 1, 0, "R8 ignored primary not used");
        tick(2, 0, 0, 1, "R8 new duty applied");

        // R9 duty zero and duty above period
        wreg(1, 0, 3, 0, "R9 zero duty buffered");
        tick(5, 1, 0, 0, "R9 zero duty stays low");
        tick(0, 0, 0, 0, "R9 zero duty count 0");
        tick(1, 0, 0, 0, "R9 zero duty count 1");
        wreg(1, 9, 2, 0, "R9 large duty buffered");
        tick(5, 1, 1, 1, "R9 large duty rises");
        for (int k = 0; k < 5; k++)
            tick(16'(k), 0, 1, 0, "R9 large duty holds");
        tick(5, 1, 1, 0, "R9 period keeps high");
        tick(0, 0, 1, 0, "R9 next period high");

        wmode(3'd0, 0, "R11 off from pwm");
        tick(500, 0, 0, 0, "R10 quiet after off");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule